// File: doc/BRIEF.md
# Relocatable Index/Data Register Port

This block lets a host reach a bank of fifteen 8-bit control registers through just two I/O addresses. The host first writes a register number to the index port. It then reads or writes the data port, which sits at the next address, to reach the register that number selects. The index stays latched, so any number of data accesses can follow without rewriting it.

The port's base address is one of four fixed choices. A new choice is accepted only in configuration mode and is held there as a pending value. The decoder switches to it at the first clock edge that samples configuration mode low. Outside configuration mode the port answers only while a global enable input is high.

During configuration mode a separate window path reaches the same registers directly by number, without going through the index latch. The register contents are exported as one flat vector for the logic that uses them.

Top module: `ioidx_port`

## Requirements
- R1: After reset the index port decodes at 0x00EA and the data port at 0x00EB. The index latch and all fifteen registers are zero.
- R2: The data port address is always the index port address plus one.
- R3: A base write with cfgBaseData equal to 0xE0, 0xE2, 0xE4 or 0xEA stages that base. Any other value, or any base write while cfgMode is 0, leaves the staged base unchanged.
- R4: While cfgMode is 1 the port keeps decoding at the previously active base, even after a new base has been staged. The active base takes the staged value at each clock edge that samples cfgMode low.
- R5: With cfgMode 0 and runEn 0 neither port address is decoded. Reads are not driven and writes change no state. With cfgMode 1 the port decodes regardless of runEn.
- R6: A decoded write to the index port latches the full 8-bit value. A decoded read of the index port returns that value.
- R7: With an index from 0x01 to 0x0F, a decoded data read returns that register and a decoded data write replaces it.
- R8: With an index of 0x00 or above 0x0F, a decoded data read returns 0xFF and a decoded data write changes no register.
- R9: The index latch changes only on a decoded index-port write. Data accesses leave it as it was.
- R10: ioRdDrive is 1 only during a decoded read, and ioRdData is 0x00 whenever ioRdDrive is 0.
- R11: cfgRegRdData returns register cfgRegIdx (0x01 to 0x0F) or 0xFF for any other index. cfgRegWr writes register cfgRegIdx only while cfgMode is 1, and it wins over a port data write to the same register in the same cycle.
- R12: regBank bits [8*(n-1)+7 : 8*(n-1)] hold register n, for n from 1 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | Host I/O address |
| ioRd | input | 1 | Single-cycle host read strobe |
| ioWr | input | 1 | Single-cycle host write strobe |
| ioWrData | input | 8 | Host write data |
| ioRdData | output | 8 | Host read data, zero when not driven |
| ioRdDrive | output | 1 | High while a decoded read is being answered |
| runEn | input | 1 | Global run-mode port enable |
| cfgMode | input | 1 | Configuration mode active |
| cfgBaseWr | input | 1 | Stage a new base address |
| cfgBaseData | input | 8 | Requested base address (low byte) |
| cfgRegWr | input | 1 | Configuration window register write |
| cfgRegIdx | input | 8 | Configuration window register number |
| cfgRegWrData | input | 8 | Configuration window write data |
| cfgRegRdData | output | 8 | Configuration window read data |
| regBank | output | 120 | Flat register contents, register 1 in the low byte |

## Verification
The bench targets the base switch-over. It stages a new base while still in configuration mode and confirms that the old base keeps answering until the exit. A design that applied the base at once, or never applied it, would decode the wrong pair of addresses. It also stages illegal base values. A design that accepted them would move the port to an address that no legal setting allows. Indices 0x00, 0x10 and 0xFF are driven through the data port. A design that used only the low four bits would alias them onto real registers and corrupt them. With runEn low, a write followed by a readback after re-enabling exposes a design that leaked writes while it was supposed to be deaf.

// File: rtl/ioidx_pkg.sv
package ioidx_pkg;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic dataWr;
    logic dataRd;
  } portStb_t;

  localparam logic [1:0] BASE_CODE_RESET = 2'd3;

  function automatic logic [7:0] baseOfCode(input logic [1:0] code);
    case (code)
      2'd0:    return 8'hE0;
      2'd1:    return 8'hE2;
      2'd2:    return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

endpackage

// File: rtl/ioidx_ctrl.sv
module ioidx_ctrl
  import ioidx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              runEn,
  input  logic              cfgMode,
  input  logic              cfgBaseWr,
  input  logic [7:0]        cfgBaseData,
  output portStb_t          stb
);

  localparam int PAD_W = ADDR_W - 8;

  logic [1:0]        pendingCode;
  logic [1:0]        activeCode;
  logic [1:0]        reqCode;
  logic              reqLegal;
  logic              portOn;
  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic              idxHit;
  logic              dataHit;

  always_comb begin
    reqLegal = 1'b1;
    reqCode  = BASE_CODE_RESET;
    case (cfgBaseData)
      8'hE0:   reqCode = 2'd0;
      8'hE2:   reqCode = 2'd1;
      8'hE4:   reqCode = 2'd2;
      8'hEA:   reqCode = 2'd3;
      default: reqLegal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingCode <= BASE_CODE_RESET;
      activeCode  <= BASE_CODE_RESET;
    end else begin
      if (cfgMode && cfgBaseWr && reqLegal) pendingCode <= reqCode;
      if (!cfgMode) activeCode <= pendingCode;
    end
  end

  assign portOn   = cfgMode || runEn;
  assign idxAddr  = {{PAD_W{1'b0}}, baseOfCode(activeCode)};
  assign dataAddr = idxAddr + ADDR_W'(1);
  assign idxHit   = portOn && (ioAddr == idxAddr);
  assign dataHit  = portOn && (ioAddr == dataAddr);

  assign stb.idxWr  = idxHit && ioWr;
  assign stb.idxRd  = idxHit && ioRd;
  assign stb.dataWr = dataHit && ioWr;
  assign stb.dataRd = dataHit && ioRd;

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode && !runEn) |-> (stb == '0));

  assert_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> (activeCode == pendingCode));

  assert_stage_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode || !cfgBaseWr) |=> $stable(pendingCode));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && $past(cfgMode)) |-> $stable(activeCode));

endmodule

// File: rtl/ioidx_dpath.sv
module ioidx_dpath
  import ioidx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  portStb_t                   stb,
  input  logic [DATA_W-1:0]          ioWrData,
  input  logic                       cfgMode,
  input  logic                       cfgRegWr,
  input  logic [DATA_W-1:0]          cfgRegIdx,
  input  logic [DATA_W-1:0]          cfgRegWrData,
  output logic [DATA_W-1:0]          portRdData,
  output logic [DATA_W-1:0]          cfgRegRdData,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  localparam logic [DATA_W-1:0] EMPTY_VAL = '1;

  logic [DATA_W-1:0] indexQ;
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [NUM_REGS-1:0] portWrEn;
  logic [NUM_REGS-1:0] winWrEn;
  logic [DATA_W-1:0] dataVal;
  logic              idxBad;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSel
    assign portWrEn[g] = stb.dataWr && (indexQ == DATA_W'(g + 1));
    assign winWrEn[g]  = cfgMode && cfgRegWr && (cfgRegIdx == DATA_W'(g + 1));
    assign regBank[g*DATA_W +: DATA_W] = regQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= '0;
    end else if (stb.idxWr) begin
      indexQ <= ioWrData;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) regQ[i] <= '0;
      else if (winWrEn[i]) regQ[i] <= cfgRegWrData;
      else if (portWrEn[i]) regQ[i] <= ioWrData;
    end
  end

  always_comb begin
    dataVal = EMPTY_VAL;
    for (int i = 0; i < NUM_REGS; i++)
      if (indexQ == DATA_W'(i + 1)) dataVal = regQ[i];
  end

  always_comb begin
    cfgRegRdData = EMPTY_VAL;
    for (int i = 0; i < NUM_REGS; i++)
      if (cfgRegIdx == DATA_W'(i + 1)) cfgRegRdData = regQ[i];
  end

  always_comb begin
    if (stb.idxRd)       portRdData = indexQ;
    else if (stb.dataRd) portRdData = dataVal;
    else                 portRdData = '0;
  end

  assign idxBad = (indexQ == '0) || (indexQ > DATA_W'(NUM_REGS));

  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.idxWr |=> $stable(indexQ));

  assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataRd && idxBad) |-> (portRdData == EMPTY_VAL));

  assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWr && idxBad && !(cfgMode && cfgRegWr)) |=> $stable(regBank));

endmodule

// File: rtl/ioidx_port.sv
module ioidx_port
  import ioidx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          ioAddr,
  input  logic                       ioRd,
  input  logic                       ioWr,
  input  logic [DATA_W-1:0]          ioWrData,
  output logic [DATA_W-1:0]          ioRdData,
  output logic                       ioRdDrive,
  input  logic                       runEn,
  input  logic                       cfgMode,
  input  logic                       cfgBaseWr,
  input  logic [7:0]                 cfgBaseData,
  input  logic                       cfgRegWr,
  input  logic [DATA_W-1:0]          cfgRegIdx,
  input  logic [DATA_W-1:0]          cfgRegWrData,
  output logic [DATA_W-1:0]          cfgRegRdData,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  portStb_t          stb;
  logic [DATA_W-1:0] portRdData;

  ioidx_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .runEn(runEn), .cfgMode(cfgMode), .cfgBaseWr(cfgBaseWr),
    .cfgBaseData(cfgBaseData), .stb(stb)
  );

  ioidx_dpath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWrData(ioWrData),
    .cfgMode(cfgMode), .cfgRegWr(cfgRegWr), .cfgRegIdx(cfgRegIdx),
    .cfgRegWrData(cfgRegWrData), .portRdData(portRdData),
    .cfgRegRdData(cfgRegRdData), .regBank(regBank)
  );

  assign ioRdDrive = stb.idxRd || stb.dataRd;
  assign ioRdData  = portRdData;

  assert_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> !ioRdDrive);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ioRdDrive |-> (ioRdData == '0));

endmodule

// File: tb/ioidx_port_test.sv
module ioidx_port_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  ioAddr = '0;
  logic         ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0]   ioWrData = '0;
  logic [7:0]   ioRdData;
  logic         ioRdDrive;
  logic         runEn = 1'b1, cfgMode = 1'b0;
  logic         cfgBaseWr = 1'b0;
  logic [7:0]   cfgBaseData = '0;
  logic         cfgRegWr = 1'b0;
  logic [7:0]   cfgRegIdx = '0, cfgRegWrData = '0;
  logic [7:0]   cfgRegRdData;
  logic [119:0] regBank;

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  logic [1:0] mActive = 2'd3, mPend = 2'd3;
  logic [7:0] mIdx = '0;
  logic [7:0] mBank [16];

  always #2.5 clk = ~clk;

  ioidx_port uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .ioRdDrive(ioRdDrive),
    .runEn(runEn), .cfgMode(cfgMode), .cfgBaseWr(cfgBaseWr),
    .cfgBaseData(cfgBaseData), .cfgRegWr(cfgRegWr), .cfgRegIdx(cfgRegIdx),
    .cfgRegWrData(cfgRegWrData), .cfgRegRdData(cfgRegRdData), .regBank(regBank)
  );

  function automatic logic [7:0] benchBase(input logic [1:0] c);
    case (c)
      2'd0: return 8'hE0; 2'd1: return 8'hE2; 2'd2: return 8'hE4; default: return 8'hEA;
    endcase
  endfunction

  function automatic logic [7:0] regOrFF(input logic [7:0] i);
    return (i >= 8'd1 && i <= 8'd15) ? mBank[i[3:0]] : 8'hFF;
  endfunction

  function automatic logic [8:0] expPort(input logic [15:0] a);
    logic [15:0] b = {8'h00, benchBase(mActive)};
    if (!cfgMode && !runEn) return 9'h000;
    if (a == b) return {1'b1, mIdx};
    if (a == b + 16'd1) return {1'b1, regOrFF(mIdx)};
    return 9'h000;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] b = {8'h00, benchBase(mActive)};
    bit on = cfgMode || runEn;
    @(negedge clk); ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
    if (on && a == b) mIdx = d;
    else if (on && a == b + 16'd1 && mIdx >= 8'd1 && mIdx <= 8'd15) mBank[mIdx[3:0]] = d;
  endtask

  task automatic ioRead(input string req, input logic [15:0] a);
    logic [8:0] e;
    @(negedge clk); ioAddr = a; ioRd = 1'b1;
    #1;
    e = expPort(a);
    chk(req, {ioRdDrive, ioRdData}, e);
    @(negedge clk); ioRd = 1'b0;
  endtask

  task automatic setCfg(input logic v);
    @(negedge clk); cfgMode = v;
    @(negedge clk);
    if (!v) mActive = mPend;
  endtask

  task automatic stageBase(input logic [7:0] d);
    @(negedge clk); cfgBaseWr = 1'b1; cfgBaseData = d;
    @(negedge clk); cfgBaseWr = 1'b0;
    if (cfgMode) begin
      case (d)
        8'hE0: mPend = 2'd0; 8'hE2: mPend = 2'd1;
        8'hE4: mPend = 2'd2; 8'hEA: mPend = 2'd3;
        default: ;
      endcase
    end
  endtask

  task automatic winWrite(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); cfgRegWr = 1'b1; cfgRegIdx = i; cfgRegWrData = d;
    @(negedge clk); cfgRegWr = 1'b0;
    if (cfgMode && i >= 8'd1 && i <= 8'd15) mBank[i[3:0]] = d;
  endtask

  task automatic winRead(input string req, input logic [7:0] i);
    @(negedge clk); cfgRegIdx = i; #1;
    chk(req, cfgRegRdData, regOrFF(i));
  endtask

  task automatic bankCheck(input string req);
    logic [119:0] e;
    for (int n = 1; n <= 15; n++) e[(n-1)*8 +: 8] = mBank[n];
    @(negedge clk); #1;
    chk(req, regBank, e);
  endtask

  function automatic logic [15:0] pickAddr();
    logic [15:0] c [10] = '{16'hE0, 16'hE1, 16'hE2, 16'hE3, 16'hE4,
                            16'hE5, 16'hEA, 16'hEB, 16'h1EA, 16'hEC};
    return c[$urandom % 10];
  endfunction

  function automatic logic [7:0] pickBase();
    logic [7:0] c [6] = '{8'hE0, 8'hE2, 8'hE4, 8'hEA, 8'hE6, 8'hE1};
    return c[$urandom % 6];
  endfunction

  initial begin
    for (int n = 0; n < 16; n++) mBank[n] = '0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    bankCheck("R1 bank zero");
    ioRead("R1 index at EA", 16'h00EA);
    ioRead("R1 data at EB", 16'h00EB);
    ioRead("R1 nothing at E0", 16'h00E0);
    ioRead("R10 idle address undriven", 16'h0100);

    // R6 R7 R9 index latch and data access
    ioWrite(16'h00EA, 8'h05);
    ioRead("R6 index readback", 16'h00EA);
    ioWrite(16'h00EB, 8'h3C);
    ioRead("R7 data readback", 16'h00EB);
    ioRead("R9 repeat data read", 16'h00EB);
    ioRead("R9 index unchanged", 16'h00EA);

    // R8 out-of-range indices
    ioWrite(16'h00EA, 8'h00); ioWrite(16'h00EB, 8'h77);
    ioRead("R8 index 00 reads FF", 16'h00EB);
    ioWrite(16'h00EA, 8'h10); ioWrite(16'h00EB, 8'h66);
    ioRead("R8 index 10 reads FF", 16'h00EB);
    ioWrite(16'h00EA, 8'hFF); ioWrite(16'h00EB, 8'h55);
    bankCheck("R8 bank untouched");
    ioWrite(16'h00EA, 8'h0F); ioWrite(16'h00EB, 8'hA5);
    ioRead("R7 top register", 16'h00EB);

    // R5 run gate
    runEn = 1'b0;
    ioRead("R5 index silent", 16'h00EA);
    ioRead("R5 data silent", 16'h00EB);
    ioWrite(16'h00EA, 8'h03); ioWrite(16'h00EB, 8'h99);
    runEn = 1'b1;
    ioRead("R5 index kept", 16'h00EA);
    ioRead("R5 data kept", 16'h00EB);

    // R3 outside cfg mode ignored
    stageBase(8'hE2);
    setCfg(1'b0);
    ioRead("R3 base write outside cfg ignored", 16'h00EA);

    // R4 staging; R5 cfg mode decodes with runEn low
    setCfg(1'b1);
    runEn = 1'b0;
    stageBase(8'hE2);
    ioRead("R4 old base during cfg", 16'h00EA);
    ioRead("R4 new base not yet", 16'h00E2);
    stageBase(8'hE6);
    setCfg(1'b0);
    runEn = 1'b1;
    ioRead("R4 new index base", 16'h00E2);
    ioRead("R2 data at base plus one", 16'h00E3);
    ioRead("R4 old base released", 16'h00EA);

    // R11 window
    setCfg(1'b1);
    winWrite(8'h07, 8'hC3);
    winRead("R11 window readback", 8'h07);
    winRead("R11 window bad index", 8'h00);
    winWrite(8'h10, 8'h11);
    bankCheck("R11 bad window write ignored");
    setCfg(1'b0);
    winWrite(8'h07, 8'h00);
    winRead("R11 window write outside cfg ignored", 8'h07);
    ioWrite(16'h00E2, 8'h07);
    ioRead("R11 port sees window data", 16'h00E3);
    bankCheck("R12 bank layout");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 10;
      logic [15:0] a = pickAddr();
      if (r < 3) begin
        ioWrite(a, ($urandom % 3 == 0) ? 8'($urandom % 20) : 8'($urandom));
      end else if (r < 6) begin
        ioRead("R7 random port read", a);
      end else if (r == 6) begin
        runEn = ~runEn;
      end else if (r == 7) begin
        setCfg(1'b1);
        stageBase(pickBase());
        ioRead("R4 random read in cfg", a);
        setCfg(1'b0);
        ioRead("R2 random read after exit", a);
      end else if (r == 8) begin
        setCfg(1'b1);
        winWrite(8'($urandom % 18), 8'($urandom));
        winRead("R11 random window read", 8'($urandom % 18));
        setCfg(1'b0);
      end else begin
        bankCheck("R12 random bank");
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nErrors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule